// File: doc/BRIEF.md
# Multi-Data Serial FIFO Holding-Register Port

This block sits between a CPU register interface and the transmit and receive byte FIFOs of a serial port. The CPU reads received bytes through a receive holding register and writes bytes to send through a transmit holding register. The serializer pops transmit bytes and pushes received bytes through a separate byte-wide side. The FIFO storage is held inside the block.

When the FIFOs are enabled and the port runs in multiple-data mode, a word access moves up to four bytes in one transfer. A byte access always moves exactly one byte. When a 9-bit data option or one of the bus-protocol port modes is selected, the port falls back to single-data mode. In that mode every access moves one item.

Two ready flags tell software when a transfer of its chosen size can proceed. Each flag has a programmable threshold of one, two or four entries. Pointer-error flags record any transfer that found fewer entries or less room than it asked for.

Top module: `fifo_hold_port`

## Requirements
- R1: After reset the FIFOs are disabled and both are empty. Both levels read 0, `rx_rdy` is 0, `tx_rdy` is 1, and both pointer-error flags are 0.
- R2: In multiple-data mode, a word read pops min(4, RX level) bytes. The oldest byte is on bits 7:0 and later bytes go to higher byte lanes. Lanes with no byte read as zero, and the data is valid in the same cycle as `rhr_re`.
- R3: In multiple-data mode, a word write pushes its four byte lanes in order, starting with lane 7:0. `tx_data` always shows the oldest TX byte.
- R4: A byte access (`rhr_word`/`thr_word` = 0) moves exactly one byte in any mode. A read returns that byte on bits 7:0 and zero above.
- R5: Single-data mode applies when `cfg_nine_bit` is 1, or when `cfg_port_mode` is 4'h9, 4'hA or 4'hB, or when the FIFOs are disabled. In this mode a word access moves one byte and read bits 31:8 are zero.
- R6: A read that asks for more bytes than are stored sets `rx_ptr_err`. A write that asks for more room than is free sets `tx_ptr_err` and keeps only the lowest lanes that fit. Both flags are sticky.
- R7: A write to the ready-mode register takes the TX ready mode from `fmr_wdata[1:0]` and the RX ready mode from `fmr_wdata[5:4]`. Code 0 selects one entry, code 1 selects two, and codes 2 and 3 select four.
- R8: `rx_rdy` is 1 when the RX level is at least the RX threshold. `tx_rdy` is 1 when the free TX entries are at least the TX threshold.
- R9: On a cycle with `cmd_valid`, the command bits act as follows.
  - `cmd[0]` empties the TX FIFO and clears `tx_ptr_err`.
  - `cmd[1]` does the same for the RX FIFO and `rx_ptr_err`.
  - `cmd[2]` enables the FIFOs.
  - `cmd[3]` disables them, and wins over `cmd[2]`.
  - Enable and disable flush both FIFOs.
  - A FIFO that is flushed ignores all data movement in that cycle.
- R10: While the FIFOs are disabled, each direction holds at most one byte and both thresholds are one.
- R11: An `rx_push` into a full RX FIFO is dropped. A `tx_pop` on an empty TX FIFO is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_nine_bit | input | 1 | 9-bit data option, forces single-data mode |
| cfg_port_mode | input | 4 | Port mode; 9, A, B force single-data mode |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 4 | {disable, enable, RX clear, TX clear} |
| fmr_we | input | 1 | Ready-mode register write |
| fmr_wdata | input | 8 | Ready modes: TX at 1:0, RX at 5:4 |
| thr_we | input | 1 | Transmit holding register write |
| thr_word | input | 1 | 1 = word access, 0 = byte access |
| thr_wdata | input | 32 | Write data, lane 0 first |
| rhr_re | input | 1 | Receive holding register read |
| rhr_word | input | 1 | 1 = word access, 0 = byte access |
| rhr_rdata | output | 32 | Read data, combinational, valid in the read cycle |
| rx_push | input | 1 | Serializer pushes a received byte |
| rx_data | input | 8 | Received byte |
| tx_pop | input | 1 | Serializer takes the oldest TX byte |
| tx_data | output | 8 | Oldest TX byte |
| rx_level | output | CW | RX entries stored |
| tx_level | output | CW | TX entries stored |
| rx_rdy | output | 1 | RX threshold reached |
| tx_rdy | output | 1 | TX free space at threshold |
| rx_ptr_err | output | 1 | Sticky RX short-read flag |
| tx_ptr_err | output | 1 | Sticky TX overfill flag |

## Verification
Read data and `tx_data` are combinational from the FIFO head. They are due in the cycle of the access itself, so the bench compares them one nanosecond after the falling edge on which the access was driven, before the capturing rising edge. Levels, ready flags and pointer-error flags change on the rising edge that accepts the access. The bench compares them at the following falling edge, against a queue model that is advanced only at that edge using the state from before the access. This keeps same-cycle pushes, pops and flushes in the right order.

// File: rtl/fifo_hold_port.sv
module fifo_hold_port #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_nine_bit,
  input  logic [3:0]    cfg_port_mode,
  input  logic          cmd_valid,
  input  logic [3:0]    cmd,
  input  logic          fmr_we,
  input  logic [7:0]    fmr_wdata,
  input  logic          thr_we,
  input  logic          thr_word,
  input  logic [31:0]   thr_wdata,
  input  logic          rhr_re,
  input  logic          rhr_word,
  output logic [31:0]   rhr_rdata,
  input  logic          rx_push,
  input  logic [7:0]    rx_data,
  input  logic          tx_pop,
  output logic [7:0]    tx_data,
  output logic [CW-1:0] rx_level,
  output logic [CW-1:0] tx_level,
  output logic          rx_rdy,
  output logic          tx_rdy,
  output logic          rx_ptr_err,
  output logic          tx_ptr_err
);

  logic [7:0]    rxm [DEPTH];
  logic [7:0]    txm [DEPTH];
  logic [AW-1:0] rx_rp, rx_wp, tx_rp, tx_wp;
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic          en;
  logic [1:0]    tx_rm, rx_rm;

  function automatic logic [CW-1:0] need_of(input logic [1:0] c);
    return (c == 2'd0) ? CW'(1) : (c == 2'd1) ? CW'(2) : CW'(4);
  endfunction

  wire single = cfg_nine_bit | (cfg_port_mode == 4'h9) | (cfg_port_mode == 4'hA)
              | (cfg_port_mode == 4'hB);
  wire multi  = en & ~single;
  wire [CW-1:0] cap     = en ? CW'(DEPTH) : CW'(1);
  wire [CW-1:0] rx_need = en ? need_of(rx_rm) : CW'(1);
  wire [CW-1:0] tx_need = en ? need_of(tx_rm) : CW'(1);
  wire [CW-1:0] tx_free = cap - tx_cnt;

  wire rx_clr = cmd_valid & (cmd[1] | cmd[2] | cmd[3]);
  wire tx_clr = cmd_valid & (cmd[0] | cmd[2] | cmd[3]);

  wire [CW-1:0] rd_req   = !rhr_re ? '0 : (rhr_word && multi) ? CW'(4) : CW'(1);
  wire          rd_short = !rx_clr && (rd_req > rx_cnt);
  wire [CW-1:0] rd_n     = rx_clr ? '0 : (rd_req > rx_cnt) ? rx_cnt : rd_req;
  wire          rx_acc   = rx_push & ~rx_clr & (rx_cnt < cap);

  wire [CW-1:0] wr_req   = !thr_we ? '0 : (thr_word && multi) ? CW'(4) : CW'(1);
  wire          wr_short = !tx_clr && (wr_req > tx_free);
  wire [CW-1:0] wr_n     = tx_clr ? '0 : (wr_req > tx_free) ? tx_free : wr_req;
  wire          tx_acc   = tx_pop & ~tx_clr & (tx_cnt != '0);

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign rhr_rdata[8*g +: 8] = (CW'(g) < rd_n) ? rxm[rx_rp + AW'(g)] : 8'h00;
  end

  assign tx_data    = txm[tx_rp];
  assign rx_level   = rx_cnt;
  assign tx_level   = tx_cnt;
  assign rx_rdy     = rx_cnt >= rx_need;
  assign tx_rdy     = tx_free >= tx_need;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0;
      tx_rm <= 2'd0;
      rx_rm <= 2'd0;
      rx_rp <= '0; rx_wp <= '0; rx_cnt <= '0; rx_ptr_err <= 1'b0;
      tx_rp <= '0; tx_wp <= '0; tx_cnt <= '0; tx_ptr_err <= 1'b0;
    end else begin
      if (cmd_valid && cmd[3]) en <= 1'b0;
      else if (cmd_valid && cmd[2]) en <= 1'b1;
      if (fmr_we) begin
        tx_rm <= fmr_wdata[1:0];
        rx_rm <= fmr_wdata[5:4];
      end
      if (rx_clr) begin
        rx_rp <= '0; rx_wp <= '0; rx_cnt <= '0; rx_ptr_err <= 1'b0;
      end else begin
        rx_rp  <= rx_rp + AW'(rd_n);
        rx_wp  <= rx_wp + AW'(rx_acc);
        rx_cnt <= rx_cnt - rd_n + CW'(rx_acc);
        if (rd_short) rx_ptr_err <= 1'b1;
      end
      if (tx_clr) begin
        tx_rp <= '0; tx_wp <= '0; tx_cnt <= '0; tx_ptr_err <= 1'b0;
      end else begin
        tx_rp  <= tx_rp + AW'(tx_acc);
        tx_wp  <= tx_wp + AW'(wr_n);
        tx_cnt <= tx_cnt + wr_n - CW'(tx_acc);
        if (wr_short) tx_ptr_err <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rx_acc) rxm[rx_wp] <= rx_data;
    for (int i = 0; i < 4; i++)
      if (CW'(i) < wr_n) txm[tx_wp + AW'(i)] <= thr_wdata[8*i +: 8];
  end

  AST_RX_WITHIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= cap);  // R11
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rhr_re && rx_level == '0) |-> rhr_rdata == 32'h0);  // R2
  AST_SINGLE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rhr_re && !multi) |-> rhr_rdata[31:8] == 24'h0);  // R5
  AST_RXCLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd[1]) |=> (rx_level == '0 && !rx_ptr_err));  // R9
  AST_TX_SHORT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_we && thr_word && multi && !tx_clr && tx_free < CW'(4)) |=> tx_ptr_err);  // R6
  AST_TXPOP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && tx_level == '0 && !thr_we && !cmd_valid) |=> tx_level == '0);  // R11

endmodule

// File: tb/sim_fifo_hold_port.sv
`timescale 1ns/1ps
module sim_fifo_hold_port;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 0, rst_n = 0;
  logic cfg_nine_bit = 0; logic [3:0] cfg_port_mode = 0;
  logic cmd_valid = 0; logic [3:0] cmd = 0;
  logic fmr_we = 0; logic [7:0] fmr_wdata = 0;
  logic thr_we = 0, thr_word = 0; logic [31:0] thr_wdata = 0;
  logic rhr_re = 0, rhr_word = 0; logic [31:0] rhr_rdata;
  logic rx_push = 0; logic [7:0] rx_data = 0;
  logic tx_pop = 0; logic [7:0] tx_data;
  logic [CW-1:0] rx_level, tx_level;
  logic rx_rdy, tx_rdy, rx_ptr_err, tx_ptr_err;

  fifo_hold_port #(.DEPTH(DEPTH)) u0 (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] rq[$], tq[$];
  logic m_en = 0, m_rerr = 0, m_terr = 0;
  logic [1:0] m_trm = 0, m_rrm = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int need_of(logic [1:0] c);
    return (c == 0) ? 1 : (c == 1) ? 2 : 4;
  endfunction

  function automatic bit m_multi();
    return m_en && !(cfg_nine_bit || cfg_port_mode == 4'h9 ||
                     cfg_port_mode == 4'hA || cfg_port_mode == 4'hB);
  endfunction

  task automatic check_state(string tag);
    int cap = m_en ? DEPTH : 1;
    int rn = m_en ? need_of(m_rrm) : 1;
    int tn = m_en ? need_of(m_trm) : 1;
    chk({tag, "/R11 rx_level"}, 32'(rx_level), 32'(rq.size()));
    chk({tag, "/R3 tx_level"}, 32'(tx_level), 32'(tq.size()));
    chk({tag, "/R8 rx_rdy"}, 32'(rx_rdy), 32'(rq.size() >= rn));
    chk({tag, "/R8 tx_rdy"}, 32'(tx_rdy), 32'(cap - tq.size() >= tn));
    chk({tag, "/R6 rx_ptr_err"}, 32'(rx_ptr_err), 32'(m_rerr));
    chk({tag, "/R6 tx_ptr_err"}, 32'(tx_ptr_err), 32'(m_terr));
  endtask

  task automatic do_cycle(string tag);
    int cap = m_en ? DEPTH : 1;
    bit mult = m_multi();
    bit rclr = cmd_valid && (cmd[1] || cmd[2] || cmd[3]);
    bit tclr = cmd_valid && (cmd[0] || cmd[2] || cmd[3]);
    int rpre = rq.size(), tpre = tq.size();
    int rreq = rhr_re ? ((rhr_word && mult) ? 4 : 1) : 0;
    int wreq = thr_we ? ((thr_word && mult) ? 4 : 1) : 0;
    int rn = (rreq > rpre) ? rpre : rreq;
    int wn = (wreq > cap - tpre) ? cap - tpre : wreq;
    logic [31:0] exp = 0;
    #1;
    if (rhr_re && !rclr) begin
      for (int i = 0; i < rn; i++) exp[8*i +: 8] = rq[i];
      chk({tag, (rhr_word && mult) ? "/R2 rdata" : !rhr_word ? "/R4 rdata" : "/R5 rdata"},
          rhr_rdata, exp);
    end
    if (tpre > 0) chk({tag, "/R3 tx_data"}, 32'(tx_data), 32'(tq[0]));
    @(posedge clk);
    if (rclr) begin rq.delete(); m_rerr = 0; end
    else begin
      for (int i = 0; i < rn; i++) void'(rq.pop_front());
      if (rreq > rpre) m_rerr = 1;
      if (rx_push && rpre < cap) rq.push_back(rx_data);
    end
    if (tclr) begin tq.delete(); m_terr = 0; end
    else begin
      if (tx_pop && tpre > 0) void'(tq.pop_front());
      for (int i = 0; i < wn; i++) tq.push_back(thr_wdata[8*i +: 8]);
      if (wreq > cap - tpre) m_terr = 1;
    end
    if (fmr_we) begin m_trm = fmr_wdata[1:0]; m_rrm = fmr_wdata[5:4]; end
    if (cmd_valid && cmd[3]) m_en = 0; else if (cmd_valid && cmd[2]) m_en = 1;
    @(negedge clk);
    cmd_valid = 0; cmd = 0; fmr_we = 0; thr_we = 0; rhr_re = 0;
    rx_push = 0; tx_pop = 0;
    check_state(tag);
  endtask

  task automatic push_rx(logic [7:0] b, string tag);
    rx_push = 1; rx_data = b; do_cycle(tag);
  endtask
  task automatic read(bit w, string tag);
    rhr_re = 1; rhr_word = w; do_cycle(tag);
  endtask
  task automatic write(bit w, logic [31:0] d, string tag);
    thr_we = 1; thr_word = w; thr_wdata = d; do_cycle(tag);
  endtask
  task automatic command(logic [3:0] c, string tag);
    cmd_valid = 1; cmd = c; do_cycle(tag);
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL R1 watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_state("R1 reset");
    // R10: disabled, one entry per direction
    push_rx(8'h11, "R10"); push_rx(8'h22, "R10");
    read(1, "R10");
    write(1, 32'hAABBCCDD, "R10");
    chk("R10 tx_data lane0", 32'(tx_data), 32'hDD);
    command(4'b0001, "R9 txclr");
    command(4'b0100, "R9 enable");
    // R7: RX ready mode four, TX ready mode two
    fmr_we = 1; fmr_wdata = 8'h21; do_cycle("R7");
    push_rx(8'h01, "R7"); push_rx(8'h02, "R7"); push_rx(8'h03, "R7");
    chk("R7 rx_rdy below four", 32'(rx_rdy), 0);
    push_rx(8'h04, "R7");
    chk("R7 rx_rdy at four", 32'(rx_rdy), 1);
    read(1, "R2 full word");
    push_rx(8'h55, "R6"); push_rx(8'h66, "R6");
    read(1, "R6 short word");
    chk("R6 short read flag", 32'(rx_ptr_err), 1);
    command(4'b0010, "R9 rxclr");
    // R5: single-data forced modes
    cfg_nine_bit = 1;
    push_rx(8'h77, "R5"); push_rx(8'h88, "R5");
    read(1, "R5 nine-bit");
    cfg_nine_bit = 0; cfg_port_mode = 4'hA;
    read(1, "R5 lin");
    write(1, 32'h12345678, "R5 write");
    cfg_port_mode = 4'h0;
    push_rx(8'h9A, "R4"); read(0, "R4 byte read");
    write(0, 32'hFFFFFF5A, "R4 byte write");
    for (int i = 0; i < 4; i++) write(1, 32'h01020304 + i, "R3 fill");
    write(1, 32'hDEADBEEF, "R6 overfill");
    chk("R6 tx overfill flag", 32'(tx_ptr_err), 1);
    for (int i = 0; i < 20; i++) begin tx_pop = 1; do_cycle("R11 drain"); end
    for (int i = 0; i < 20; i++) push_rx(8'(i), "R11 overfill rx");
    command(4'b1100, "R9 disable wins");
    command(4'b0100, "R9 enable");

    for (int n = 0; n < 4000; n++) begin
      int r = $urandom % 100;
      rx_push = ($urandom % 3) == 0; rx_data = 8'($urandom);
      tx_pop = ($urandom % 3) == 0;
      if (r < 32) begin rhr_re = 1; rhr_word = 1'($urandom); end
      else if (r < 64) begin thr_we = 1; thr_word = 1'($urandom); thr_wdata = $urandom; end
      else if (r < 67) begin fmr_we = 1; fmr_wdata = 8'($urandom); end
      else if (r < 70) begin cmd_valid = 1; cmd = 4'(1 << ($urandom % 3)); end
      else if (r == 70) begin cmd_valid = 1; cmd = 4'b1000; end
      else if (r < 73) begin
        cfg_nine_bit = ($urandom % 4) == 0;
        case ($urandom % 5)
          0: cfg_port_mode = 4'h9; 1: cfg_port_mode = 4'hA;
          2: cfg_port_mode = 4'hB; default: cfg_port_mode = 4'h0;
        endcase
      end
      do_cycle("rand");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule